// File: doc/BRIEF.md
# Interrupting Peripheral I/O Port

This block connects one slow external device to a simple processor register bus. It answers only to a small window of bus addresses. In that window it offers three registers: a data register, a status register and a command register. The processor drives each operation by writing an opcode into the command register.

A READ operation asks the device for a word over a valid/ready handshake. The block checks the parity of the incoming word, latches the word and flags it as ready. If interrupts are enabled it then raises a level interrupt. Both the word and the interrupt stay in place until the processor reads the data register. A WRITE operation sends the data register, with a parity bit that the block generates, to the device. A TEST operation has no effect, so the processor can use it as a pure status probe. A CONTROL operation only updates the parity mode and the interrupt enable.

The bus is single-access: one cycle carries at most one read or one write. Read data is combinational for the cycle of the access. Side effects of the access take place at the clock edge that ends it.

Top module: `pio_unit`

## Requirements
- R1: Only addresses whose upper bits equal the upper bits of BASE_ADDR fall in the window, with the low two bits selecting the register. Offset 0 is data, offset 1 is status and offset 2 is command. An access outside the window changes no state, and a read outside the window returns 0.
- R2: After synchronous reset the block is in this state: status reads 0 (apart from the live fault bit), command readback is 0, irq is low, and both dev_rx_ready and dev_tx_valid are low.
- R3: The command word holds the opcode in bits 1:0 (0 CONTROL, 1 READ, 2 WRITE, 3 TEST), odd parity in bit 2 and interrupt enable in bit 3. Writing opcode 1 while idle sets status BUSY (bit 1) and raises dev_rx_ready from the next cycle until a device word is accepted.
- R4: When dev_rx_valid and dev_rx_ready are both high at an edge, the block latches the low 8 bits of the word. After that edge BUSY is 0, READY (status bit 0) is 1, and irq equals the interrupt enable bit.
- R5: A bus read of the data register returns the held word. After that access, READY and irq are 0.
- R6: Bit 8 of a device word is its parity bit. In even mode, the 9 bits must contain an even number of ones; in odd mode, an odd number. On a mismatch, status PARITY_ERR (bit 2) is set after the capture edge. The flag stays set until the next accepted READ command clears it.
- R7: Writing opcode 2 while not busy raises dev_tx_valid with dev_tx_word = {parity, data register}, using the parity mode written with that command. The word holds steady until dev_tx_ready is seen. BUSY is set for the whole transfer.
- R8: While BUSY, a write to the command or data register is ignored. The parity mode, interrupt enable, data and transfer in progress are all left unchanged.
- R9: Command readback shows the parity mode in bit 2 and the interrupt enable in bit 3. CONTROL updates only these two bits, and clearing the enable drops irq while READY stays set. TEST changes no state.
- R10: Status bit 3 reflects the dev_fault input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Access is a write |
| bus_rd | input | 1 | Access is a read |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read cycle |
| irq | output | 1 | Level interrupt request |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_ready | output | 1 | Block accepts a device word |
| dev_rx_word | input | 9 | Device word, bit 8 parity |
| dev_tx_valid | output | 1 | Block offers a word to the device |
| dev_tx_ready | input | 1 | Device accepts the word |
| dev_tx_word | output | 9 | Outgoing word, bit 8 parity |
| dev_fault | input | 1 | Device malfunction indication |

## Verification
A wrong sequencer state shows up at the ports within one cycle of the edge that caused it. It appears as a handshake line (dev_rx_ready or dev_tx_valid) that is wrongly high or low, or as a READY/BUSY pair that contradicts the handshake. A stale interrupt-enable or parity-mode bit does not show until a later step, but it is then visible at the port. It shows as irq staying high after the data read, as a PARITY_ERR verdict with the wrong polarity on the next capture, or as a wrong bit 8 on the next outgoing word. A command that is wrongly accepted while busy shows on the command readback or as a handshake that moves from one side to the other.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int DATA_W = 8;
    localparam int WORD_W = DATA_W + 1;
    localparam int OFF_W  = 2;

    localparam logic [OFF_W-1:0] OFF_DATA   = 2'd0;
    localparam logic [OFF_W-1:0] OFF_STATUS = 2'd1;
    localparam logic [OFF_W-1:0] OFF_CMD    = 2'd2;

    localparam int SB_READY = 0;
    localparam int SB_BUSY  = 1;
    localparam int SB_PERR  = 2;
    localparam int SB_FAULT = 3;

    typedef enum logic [1:0] {
        OP_CTRL  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_TEST  = 2'd3
    } opcode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RX   = 2'd1,
        SQ_TX   = 2'd2,
        SQ_HOLD = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic    irq_en;
        logic    odd;
        opcode_e op;
    } cmd_word_t;

    typedef struct packed {
        logic wr_data;
        logic wr_cmd;
        logic rd_data;
        logic rd_status;
        logic rd_cmd;
    } access_t;

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec
    import pio_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output access_t           acc
);
    localparam int HI_W = ADDR_W - OFF_W;

    logic             hit;
    logic [OFF_W-1:0] off;
    logic             is_wr;
    logic             is_rd;

    assign hit   = bus_sel && (bus_addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
    assign off   = bus_addr[OFF_W-1:0];
    assign is_wr = hit && bus_wr;
    assign is_rd = hit && bus_rd && !bus_wr;

    always_comb begin
        acc           = '0;
        acc.wr_data   = is_wr && (off == OFF_DATA);
        acc.wr_cmd    = is_wr && (off == OFF_CMD);
        acc.rd_data   = is_rd && (off == OFF_DATA);
        acc.rd_status = is_rd && (off == OFF_STATUS);
        acc.rd_cmd    = is_rd && (off == OFF_CMD);
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;
endmodule

// File: rtl/pio_seq.sv
module pio_seq
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WORD_W-1:0] tx_word,
    output logic              st_ready,
    output logic              st_busy,
    output logic              st_perr,
    output logic              irq_en,
    output logic              odd_mode,
    output logic [DATA_W-1:0] data_reg
);
    seq_state_e        state_q;
    cmd_word_t         cmd;
    logic              cmd_take;
    logic              rx_fire;
    logic [DATA_W-1:0] rx_data;
    logic              rx_par;

    assign cmd      = cmd_word_t'(wdata[3:0]);
    assign rx_ready = (state_q == SQ_RX);
    assign tx_valid = (state_q == SQ_TX);
    assign st_busy  = rx_ready || tx_valid;
    assign st_ready = (state_q == SQ_HOLD);
    assign cmd_take = acc.wr_cmd && !st_busy;
    assign rx_fire  = rx_ready && rx_valid;
    assign rx_data  = rx_word[DATA_W-1:0];
    assign rx_par   = rx_word[DATA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            data_reg <= '0;
            st_perr  <= 1'b0;
            irq_en   <= 1'b0;
            odd_mode <= 1'b0;
            tx_word  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE, SQ_HOLD: begin
                    if (cmd_take) begin
                        if (cmd.op != OP_TEST) begin
                            irq_en   <= cmd.irq_en;
                            odd_mode <= cmd.odd;
                        end
                        unique case (cmd.op)
                            OP_READ: begin
                                state_q <= SQ_RX;
                                st_perr <= 1'b0;
                            end
                            OP_WRITE: begin
                                state_q <= SQ_TX;
                                tx_word <= {parity_of(data_reg, cmd.odd), data_reg};
                            end
                            default: ;
                        endcase
                    end else if (acc.wr_data && state_q == SQ_IDLE) begin
                        data_reg <= wdata;
                    end else if (acc.rd_data && state_q == SQ_HOLD) begin
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_RX: begin
                    if (rx_fire) begin
                        data_reg <= rx_data;
                        st_perr  <= (rx_par != parity_of(rx_data, odd_mode));
                        state_q  <= SQ_HOLD;
                    end
                end
                SQ_TX: begin
                    if (tx_ready) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
(
    input  access_t           acc,
    input  logic [DATA_W-1:0] data_reg,
    input  logic              st_ready,
    input  logic              st_busy,
    input  logic              st_perr,
    input  logic              fault,
    input  logic              irq_en,
    input  logic              odd_mode,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] cmd_w;

    always_comb begin
        status_w           = '0;
        status_w[SB_READY] = st_ready;
        status_w[SB_BUSY]  = st_busy;
        status_w[SB_PERR]  = st_perr;
        status_w[SB_FAULT] = fault;
        cmd_w              = '0;
        cmd_w[2]           = odd_mode;
        cmd_w[3]           = irq_en;
        rdata              = '0;
        if (acc.rd_data)   rdata = data_reg;
        if (acc.rd_status) rdata = status_w;
        if (acc.rd_cmd)    rdata = cmd_w;
    end
endmodule

// File: rtl/pio_unit.sv
module pio_unit
    import pio_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              dev_rx_valid,
    output logic              dev_rx_ready,
    input  logic [WORD_W-1:0] dev_rx_word,
    output logic              dev_tx_valid,
    input  logic              dev_tx_ready,
    output logic [WORD_W-1:0] dev_tx_word,
    input  logic              dev_fault
);
    access_t           acc;
    logic              st_ready;
    logic              st_busy;
    logic              st_perr;
    logic              irq_en;
    logic              odd_mode;
    logic [DATA_W-1:0] data_reg;
    logic              data_rd_hit;
    logic              cmd_wr_hit;

    pio_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .acc     (acc)
    );

    pio_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wdata   (bus_wdata),
        .rx_valid(dev_rx_valid),
        .rx_word (dev_rx_word),
        .rx_ready(dev_rx_ready),
        .tx_valid(dev_tx_valid),
        .tx_ready(dev_tx_ready),
        .tx_word (dev_tx_word),
        .st_ready(st_ready),
        .st_busy (st_busy),
        .st_perr (st_perr),
        .irq_en  (irq_en),
        .odd_mode(odd_mode),
        .data_reg(data_reg)
    );

    pio_rdmux u_mux (
        .acc     (acc),
        .data_reg(data_reg),
        .st_ready(st_ready),
        .st_busy (st_busy),
        .st_perr (st_perr),
        .fault   (dev_fault),
        .irq_en  (irq_en),
        .odd_mode(odd_mode),
        .rdata   (bus_rdata)
    );

    assign irq         = irq_en && st_ready;
    assign data_rd_hit = acc.rd_data;
    assign cmd_wr_hit  = acc.wr_cmd;
endmodule

// File: rtl/pio_unit_chk.sv
module pio_unit_chk
    import pio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              dev_rx_valid,
    input logic              dev_rx_ready,
    input logic              dev_tx_valid,
    input logic              dev_tx_ready,
    input logic [WORD_W-1:0] dev_tx_word,
    input logic              st_ready,
    input logic              st_busy,
    input logic              data_rd_hit,
    input logic              cmd_wr_hit
);
    a_r3_rxready_means_busy: assert property (@(posedge clk) disable iff (rst)
        dev_rx_ready |-> st_busy);

    a_r4_irq_needs_ready: assert property (@(posedge clk) disable iff (rst)
        irq |-> st_ready);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (st_ready && data_rd_hit) |=> (!st_ready && !irq));

    a_r7_tx_word_held: assert property (@(posedge clk) disable iff (rst)
        (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_word)));

    a_r8_busy_ignores_cmd: assert property (@(posedge clk) disable iff (rst)
        (st_busy && cmd_wr_hit && !dev_rx_valid && !dev_tx_ready) |=> st_busy);
endmodule

bind pio_unit pio_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .dev_rx_valid(dev_rx_valid),
    .dev_rx_ready(dev_rx_ready),
    .dev_tx_valid(dev_tx_valid),
    .dev_tx_ready(dev_tx_ready),
    .dev_tx_word (dev_tx_word),
    .st_ready    (st_ready),
    .st_busy     (st_busy),
    .data_rd_hit (data_rd_hit),
    .cmd_wr_hit  (cmd_wr_hit)
);

// File: tb/tb_pio_unit.sv
module tb_pio_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       dev_rx_valid = 0;
    logic       dev_rx_ready;
    logic [8:0] dev_rx_word = 0;
    logic       dev_tx_valid;
    logic       dev_tx_ready = 0;
    logic [8:0] dev_tx_word;
    logic       dev_fault = 0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [7:0] A_DATA = 8'h40, A_STAT = 8'h41, A_CMD = 8'h42;

    always #2 clk = ~clk;

    pio_unit dut (.*);

    function automatic logic par(input logic [7:0] d, input logic odd);
        logic p = odd;
        for (int i = 0; i < 8; i++) p ^= d[i];
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic give(input logic [8:0] w);
        @(negedge clk);
        dev_rx_valid = 1; dev_rx_word = w;
        @(negedge clk);
        dev_rx_valid = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] d;
        logic       o, bad, en;
        void'($urandom(32'h1c0de5));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R2 reset state
        rd(A_STAT, r); chk(r == 8'h00, "R2 status", r, 0);
        rd(A_CMD, r);  chk(r == 8'h00, "R2 cmd", r, 0);
        chk(!irq && !dev_rx_ready && !dev_tx_valid, "R2 outputs", {irq, dev_rx_ready, dev_tx_valid}, 0);
        // R1 outside window
        wr(8'h52, 8'h09);
        chk(!dev_rx_ready, "R1 outside write", dev_rx_ready, 0);
        rd(A_STAT, r); chk(r == 8'h00, "R1 status unchanged", r, 0);
        bus_sel = 0;
        rd(8'h50, r); chk(r == 8'h00, "R1 outside read", r, 0);
        // R3/R4/R5 even, irq enabled
        wr(A_CMD, 8'h09);
        chk(dev_rx_ready, "R3 rx_ready", dev_rx_ready, 1);
        rd(A_STAT, r); chk(r == 8'h02, "R3 busy", r, 8'h02);
        give({par(8'hA7, 0), 8'hA7});
        chk(irq && !dev_rx_ready, "R4 irq raised", {irq, dev_rx_ready}, 2'b10);
        rd(A_STAT, r); chk(r == 8'h01, "R4 ready", r, 8'h01);
        rd(A_DATA, r); chk(r == 8'hA7, "R5 data", r, 8'hA7);
        chk(!irq, "R5 irq cleared", irq, 0);
        rd(A_STAT, r); chk(r == 8'h00, "R5 ready cleared", r, 0);
        // R8 busy ignores command and data
        wr(A_CMD, 8'h01);
        wr(A_CMD, 8'h0E);
        wr(A_DATA, 8'h33);
        rd(A_CMD, r); chk(r == 8'h00, "R8 cfg kept", r, 0);
        chk(dev_rx_ready && !dev_tx_valid, "R8 transfer kept", {dev_rx_ready, dev_tx_valid}, 2'b10);
        // R6 parity error, even mode
        give({~par(8'h5C, 0), 8'h5C});
        rd(A_STAT, r); chk(r == 8'h05, "R6 perr set", r, 8'h05);
        chk(!irq, "R4 irq off when disabled", irq, 0);
        wr(A_CMD, 8'h01);
        rd(A_STAT, r); chk(r == 8'h02, "R6 perr cleared by READ", r, 8'h02);
        give({par(8'h11, 0), 8'h11});
        rd(A_DATA, r); chk(r == 8'h11, "R6 data", r, 8'h11);
        // R9 CONTROL clears irq, TEST no effect
        wr(A_CMD, 8'h0D);
        give({par(8'h80, 1), 8'h80});
        chk(irq, "R9 irq before", irq, 1);
        wr(A_CMD, 8'h0F);
        rd(A_CMD, r); chk(r == 8'h0C, "R9 TEST keeps cfg", r, 8'h0C);
        chk(irq && !dev_tx_valid && !dev_rx_ready, "R9 TEST no action", {irq, dev_tx_valid, dev_rx_ready}, 3'b100);
        wr(A_CMD, 8'h04);
        chk(!irq, "R9 irq dropped", irq, 0);
        rd(A_STAT, r); chk(r == 8'h01, "R9 ready kept", r, 8'h01);
        rd(A_DATA, r); chk(r == 8'h80, "R9 data", r, 8'h80);
        // R7 write path, odd mode, stall
        wr(A_DATA, 8'h5A);
        wr(A_CMD, 8'h06);
        chk(dev_tx_valid && dev_tx_word == {par(8'h5A, 1), 8'h5A}, "R7 tx word", dev_tx_word, {par(8'h5A, 1), 8'h5A});
        repeat (2) @(negedge clk);
        chk(dev_tx_valid && dev_tx_word == {par(8'h5A, 1), 8'h5A}, "R7 held", dev_tx_word, {par(8'h5A, 1), 8'h5A});
        rd(A_STAT, r); chk(r == 8'h02, "R7 busy", r, 8'h02);
        dev_tx_ready = 1;
        @(negedge clk);
        dev_tx_ready = 0;
        chk(!dev_tx_valid, "R7 done", dev_tx_valid, 0);
        // R10 fault
        dev_fault = 1;
        rd(A_STAT, r); chk(r == 8'h08, "R10 fault", r, 8'h08);
        dev_fault = 0;
        rd(A_STAT, r); chk(r == 8'h00, "R10 fault clear", r, 0);
        // random reads and writes
        for (int i = 0; i < 40; i++) begin
            d   = 8'($urandom);
            o   = 1'($urandom);
            bad = ($urandom % 4) == 0;
            en  = 1'($urandom);
            wr(A_CMD, {4'b0, en, o, 2'b01});
            give({par(d, o) ^ bad, d});
            chk(irq == en, "R4 random irq", irq, en);
            rd(A_STAT, r); chk(r == {5'b0, bad, 2'b01}, "R6 random status", r, {5'b0, bad, 2'b01});
            rd(A_DATA, r); chk(r == d, "R5 random data", r, d);
            d = 8'($urandom);
            o = 1'($urandom);
            wr(A_DATA, d);
            wr(A_CMD, {5'b0, o, 2'b10});
            chk(dev_tx_word == {par(d, o), d}, "R7 random tx", dev_tx_word, {par(d, o), d});
            dev_tx_ready = 1;
            @(negedge clk);
            dev_tx_ready = 0;
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule